// File: doc/BRIEF.md
# Functional Unit Pool Scheduler

This block sits behind the issue stage of an out-of-order core. Each cycle the issue side offers up to eight ready micro-ops. Every offered op carries a two-bit operation class and a destination tag. The scheduler binds each op it can place to a free execution unit that serves that class. It tracks how long each unit stays occupied and returns the tag on a completion lane when the op's latency has elapsed. An op it cannot place is refused in the same cycle, and the issue side offers it again later. No operands or results pass through the block; only tags do.

The pool holds three groups:

- **Integer ALUs:** six identical single-cycle units, all fully pipelined.
- **Multiply/divide unit:** one unit shared by both classes. Multiply runs in a three-stage pipeline. Divide is iterative, takes twenty cycles and holds the whole unit while it runs, so it blocks multiplies as well as other divides.
- **Spare group:** two general-purpose units with a four-cycle, non-pipelined latency.

Each unit has its own completion lane, which carries a valid bit and a tag.

Top module: `fu_pool_sched`

## Requirements
- R1: Class encoding is ALU=0, MUL=1, DIV=2, AUX=3 in the two bits `req_cls[2i+1:2i]` of slot i. An op is only ever bound to a unit of its own group. ALU ops go to units 0..5, MUL and DIV ops go to unit 6, and AUX ops go to units 7..8.
- R2: Up to eight slots are considered per cycle. `req_accept[i]` is combinational in the same cycle. Slots are served in ascending slot index (slot 0 is oldest), and each slot takes the lowest-numbered ready unit of its group that an older slot has not already taken.
- R3: An ALU op accepted in cycle c completes in cycle c+1 on the lane of its unit. Every ALU unit accepts a new op each cycle, so an ALU op is refused only when six older ALU ops were accepted in the same cycle.
- R4: A multiply accepted in cycle c completes on lane 6 in cycle c+3. A new multiply may be accepted every cycle. The multiply/divide unit accepts at most one op per cycle.
- R5: A divide accepted in cycle c completes on lane 6 in cycle c+20. In cycles c+1 to c+19 the unit refuses both multiplies and divides. In cycle c+20 it accepts again.
- R6: An AUX op accepted in cycle c completes in cycle c+4 on lane 7 or 8. That unit refuses in cycles c+1 to c+3 and accepts again in cycle c+4.
- R7: Each completion lane u presents `cmp_valid[u]` with `cmp_tag[6u+5:6u]`, equal to the tag of the op bound to unit u. Every accepted op completes exactly once. A refused op never completes.
- R8: A slot with `req_valid` low is never accepted and has no effect on any unit, whatever its class and tag.
- R9: Synchronous active-high `rst` empties every unit pipeline and clears every busy state. In the cycle after reset no lane is valid, and all units accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 8 | Per-slot offer valid |
| req_cls | input | 16 | Per-slot operation class, 2 bits per slot |
| req_tag | input | 48 | Per-slot destination tag, 6 bits per slot |
| req_accept | output | 8 | Per-slot acceptance, same cycle |
| cmp_valid | output | 9 | Per-unit completion valid |
| cmp_tag | output | 54 | Per-unit completion tag, 6 bits per lane |

## Verification
The bench offers mixed bundles in which younger slots compete with older ones for a full group. A design that ignored slot order, or that let two slots share a unit, would show the wrong acceptance mask and would lose or duplicate completions.

It holds multiplies and divides against the shared unit throughout a divide. A design that released the unit one cycle early or late would accept or refuse at the wrong boundary. A design that let a multiply slip past a divide would put two results on lane 6 at once.

It checks the non-pipelined spare units at the edge of their blocking window in the same way. It also resets in the middle of a divide: a design that kept the busy state or the in-flight tag would refuse the next divide or emit a stale completion.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [1:0] {
        OPC_ALU = 2'd0,
        OPC_MUL = 2'd1,
        OPC_DIV = 2'd2,
        OPC_AUX = 2'd3
    } op_class_e;

endpackage

// File: rtl/fu_lane.sv
// One execution unit with a fixed latency. The PIPELINED parameter
// selects a shift register (accepts every cycle) or a countdown
// (busy until the result leaves).
module fu_lane #(
    parameter int LAT       = 1,
    parameter bit PIPELINED = 1'b1,
    parameter int TAG_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [TAG_W-1:0] go_tag,
    output logic             rdy,
    output logic             out_vld,
    output logic [TAG_W-1:0] out_tag
);

    generate
        if (PIPELINED) begin : g_pipe
            typedef struct packed {
                logic [LAT-1:0]            vld;
                logic [LAT-1:0][TAG_W-1:0] tag;
            } pipe_t;

            pipe_t st_d, st_q;

            always_comb begin
                st_d        = st_q;
                st_d.vld[0] = go;
                st_d.tag[0] = go_tag;
                for (int k = 1; k < LAT; k++) begin
                    st_d.vld[k] = st_q.vld[k-1];
                    st_d.tag[k] = st_q.tag[k-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= st_d;
            end

            assign rdy     = 1'b1;
            assign out_vld = st_q.vld[LAT-1];
            assign out_tag = st_q.tag[LAT-1];
        end else begin : g_iter
            localparam int CW = $clog2(LAT + 1);

            typedef struct packed {
                logic [CW-1:0]    cnt;
                logic [TAG_W-1:0] tag;
            } iter_t;

            iter_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (go) begin
                    st_d.cnt = CW'(LAT);
                    st_d.tag = go_tag;
                end else if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= st_d;
            end

            assign rdy     = (st_q.cnt <= CW'(1));
            assign out_vld = (st_q.cnt == CW'(1));
            assign out_tag = st_q.tag;

            if (LAT > 1) begin : g_hold
                AST_LANE_NP_HOLD: assert property (@(posedge clk) disable iff (rst)
                    go |=> !rdy); // R6
            end
        end
    endgenerate

    AST_LANE_GO_READY: assert property (@(posedge clk) disable iff (rst)
        go |-> rdy); // R2
    AST_LANE_RST_EMPTY: assert property (@(posedge clk)
        rst |=> !out_vld); // R9

endmodule

// File: rtl/fu_muldiv.sv
// Shared multiply/divide unit: pipelined multiply, blocking divide,
// one completion lane.
module fu_muldiv #(
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 20,
    parameter int TAG_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             go_div,
    input  logic [TAG_W-1:0] go_tag,
    output logic             rdy,
    output logic             out_vld,
    output logic [TAG_W-1:0] out_tag
);

    localparam int CW = $clog2(DIV_LAT + 1);

    typedef struct packed {
        logic [MUL_LAT-1:0]            mvld;
        logic [MUL_LAT-1:0][TAG_W-1:0] mtag;
        logic [CW-1:0]                 dcnt;
        logic [TAG_W-1:0]              dtag;
    } md_t;

    md_t st_d, st_q;
    logic mul_done, div_done;

    always_comb begin
        st_d         = st_q;
        st_d.mvld[0] = go && !go_div;
        st_d.mtag[0] = go_tag;
        for (int k = 1; k < MUL_LAT; k++) begin
            st_d.mvld[k] = st_q.mvld[k-1];
            st_d.mtag[k] = st_q.mtag[k-1];
        end
        if (go && go_div) begin
            st_d.dcnt = CW'(DIV_LAT);
            st_d.dtag = go_tag;
        end else if (st_q.dcnt != '0) begin
            st_d.dcnt = st_q.dcnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mul_done = st_q.mvld[MUL_LAT-1];
    assign div_done = (st_q.dcnt == CW'(1));
    assign rdy      = (st_q.dcnt <= CW'(1));
    assign out_vld  = mul_done || div_done;
    assign out_tag  = div_done ? st_q.dtag : st_q.mtag[MUL_LAT-1];

    AST_MD_SINGLE_DONE: assert property (@(posedge clk) disable iff (rst)
        !(mul_done && div_done)); // R5
    AST_MD_DIV_LOCK: assert property (@(posedge clk) disable iff (rst)
        (st_q.dcnt > CW'(1)) |-> !go); // R5
    AST_MD_DIV_START: assert property (@(posedge clk) disable iff (rst)
        (go && go_div) |=> !rdy); // R5
    AST_MD_RST_EMPTY: assert property (@(posedge clk)
        rst |=> (!out_vld && rdy)); // R9

endmodule

// File: rtl/fu_issue_arb.sv
// Oldest-first binding of offered slots to ready units of their class.
module fu_issue_arb
    import fu_pkg::*;
#(
    parameter int ISSUE_W = 8,
    parameter int N_ALU   = 6,
    parameter int N_AUX   = 2,
    parameter int TAG_W   = 6,
    localparam int N_UNITS = N_ALU + 1 + N_AUX
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [ISSUE_W-1:0]               req_valid,
    input  logic [ISSUE_W-1:0][1:0]          req_cls,
    input  logic [ISSUE_W-1:0][TAG_W-1:0]    req_tag,
    input  logic [N_UNITS-1:0]               unit_rdy,
    output logic [ISSUE_W-1:0]               req_accept,
    output logic [N_UNITS-1:0]               unit_go,
    output logic [N_UNITS-1:0][TAG_W-1:0]    unit_tag,
    output logic                             md_div
);

    localparam int MD_IDX = N_ALU;

    function automatic logic serves(input int u, input op_class_e c);
        case (c)
            OPC_ALU: return (u < N_ALU);
            OPC_MUL,
            OPC_DIV: return (u == MD_IDX);
            default: return (u > MD_IDX);
        endcase
    endfunction

    logic [ISSUE_W-1:0]            acc_w;
    logic [N_UNITS-1:0]            taken_w;
    logic [N_UNITS-1:0][TAG_W-1:0] tag_w;
    logic                          div_w;

    always_comb begin
        acc_w   = '0;
        taken_w = '0;
        tag_w   = '0;
        div_w   = 1'b0;
        for (int i = 0; i < ISSUE_W; i++) begin
            if (req_valid[i]) begin
                for (int u = 0; u < N_UNITS; u++) begin
                    if (!acc_w[i] && !taken_w[u] && unit_rdy[u] &&
                        serves(u, op_class_e'(req_cls[i]))) begin
                        acc_w[i]   = 1'b1;
                        taken_w[u] = 1'b1;
                        tag_w[u]   = req_tag[i];
                        if (u == MD_IDX && op_class_e'(req_cls[i]) == OPC_DIV)
                            div_w = 1'b1;
                    end
                end
            end
        end
    end

    assign req_accept = acc_w;
    assign unit_go    = taken_w;
    assign unit_tag   = tag_w;
    assign md_div     = div_w;

    AST_ARB_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
        (req_accept & ~req_valid) == '0); // R8
    AST_ARB_ONE_TO_ONE: assert property (@(posedge clk) disable iff (rst)
        $countones(req_accept) == $countones(unit_go)); // R2
    AST_ARB_READY_ONLY: assert property (@(posedge clk) disable iff (rst)
        (unit_go & ~unit_rdy) == '0); // R2

endmodule

// File: rtl/fu_pool_sched.sv
module fu_pool_sched #(
    parameter int ISSUE_W  = 8,
    parameter int N_ALU    = 6,
    parameter int N_AUX    = 2,
    parameter int TAG_W    = 6,
    parameter int MUL_LAT  = 3,
    parameter int DIV_LAT  = 20,
    parameter int AUX_LAT  = 4,
    parameter bit AUX_PIPE = 1'b0,
    localparam int N_UNITS = N_ALU + 1 + N_AUX
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ISSUE_W-1:0]         req_valid,
    input  logic [2*ISSUE_W-1:0]       req_cls,
    input  logic [TAG_W*ISSUE_W-1:0]   req_tag,
    output logic [ISSUE_W-1:0]         req_accept,
    output logic [N_UNITS-1:0]         cmp_valid,
    output logic [TAG_W*N_UNITS-1:0]   cmp_tag
);

    localparam int MD_IDX = N_ALU;

    logic [ISSUE_W-1:0][1:0]       cls_v;
    logic [ISSUE_W-1:0][TAG_W-1:0] tag_v;
    logic [N_UNITS-1:0]            unit_rdy;
    logic [N_UNITS-1:0]            unit_go;
    logic [N_UNITS-1:0][TAG_W-1:0] unit_tag;
    logic [N_UNITS-1:0][TAG_W-1:0] lane_tag;
    logic                          md_div;

    assign cls_v = req_cls;
    assign tag_v = req_tag;

    fu_issue_arb #(
        .ISSUE_W(ISSUE_W), .N_ALU(N_ALU), .N_AUX(N_AUX), .TAG_W(TAG_W)
    ) i_arb (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_cls   (cls_v),
        .req_tag   (tag_v),
        .unit_rdy  (unit_rdy),
        .req_accept(req_accept),
        .unit_go   (unit_go),
        .unit_tag  (unit_tag),
        .md_div    (md_div)
    );

    generate
        for (genvar k = 0; k < N_ALU; k++) begin : g_alu
            fu_lane #(.LAT(1), .PIPELINED(1'b1), .TAG_W(TAG_W)) i_lane (
                .clk    (clk),
                .rst    (rst),
                .go     (unit_go[k]),
                .go_tag (unit_tag[k]),
                .rdy    (unit_rdy[k]),
                .out_vld(cmp_valid[k]),
                .out_tag(lane_tag[k])
            );
        end
        for (genvar k = 0; k < N_AUX; k++) begin : g_aux
            fu_lane #(.LAT(AUX_LAT), .PIPELINED(AUX_PIPE), .TAG_W(TAG_W)) i_lane (
                .clk    (clk),
                .rst    (rst),
                .go     (unit_go[MD_IDX+1+k]),
                .go_tag (unit_tag[MD_IDX+1+k]),
                .rdy    (unit_rdy[MD_IDX+1+k]),
                .out_vld(cmp_valid[MD_IDX+1+k]),
                .out_tag(lane_tag[MD_IDX+1+k])
            );
        end
    endgenerate

    fu_muldiv #(.MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT), .TAG_W(TAG_W)) i_md (
        .clk    (clk),
        .rst    (rst),
        .go     (unit_go[MD_IDX]),
        .go_div (md_div),
        .go_tag (unit_tag[MD_IDX]),
        .rdy    (unit_rdy[MD_IDX]),
        .out_vld(cmp_valid[MD_IDX]),
        .out_tag(lane_tag[MD_IDX])
    );

    assign cmp_tag = lane_tag;

    AST_TOP_RST_QUIET: assert property (@(posedge clk)
        rst |=> (cmp_valid == '0)); // R9
    AST_TOP_ALU_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (unit_go[N_ALU-1:0] != '0) |=> (unit_rdy[N_ALU-1:0] == '1)); // R3

endmodule

// File: tb/test_fu_pool_sched.sv
`timescale 1ns/1ps
module test_fu_pool_sched;

    logic             clk = 1'b0;
    logic             rst;
    logic [7:0]       req_valid;
    logic [7:0][1:0]  req_cls;
    logic [7:0][5:0]  req_tag;
    logic [7:0]       req_accept;
    logic [8:0]       cmp_valid;
    logic [8:0][5:0]  cmp_tag;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fu_pool_sched i_fu_pool_sched (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_cls   (req_cls),
        .req_tag   (req_tag),
        .req_accept(req_accept),
        .cmp_valid (cmp_valid),
        .cmp_tag   (cmp_tag)
    );

    // {valid[7:0], classes[15:0], expected accept[7:0]}
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        {8'hFF, 16'h0000, 8'h3F},   // eight ALU, six units
        {8'h1F, 16'h0140, 8'h0F},   // two MUL, one per cycle
        {8'h07, 16'h003F, 8'h03},   // three AUX, two units
        {8'h60, 16'h1800, 8'h20},   // DIV older than MUL
        {8'h00, 16'hFFFF, 8'h00},   // nothing valid
        {8'h3F, 16'h03E3, 8'h2F},   // mixed bundle
        {8'h80, 16'h0000, 8'h80},   // youngest slot alone
        {8'hFF, 16'h5555, 8'h01}    // eight MUL
    };

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = '0;
        req_cls   = '0;
        req_tag   = '0;
    endtask

    task automatic offer1(input int slot, input logic [1:0] c, input logic [5:0] t);
        idle();
        req_valid[slot] = 1'b1;
        req_cls[slot]   = c;
        req_tag[slot]   = t;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(negedge clk);
        chk("R9 reset lanes idle", int'(cmp_valid), 0);
        rst = 1'b0;

        // Table walk: one bundle from idle, then drain and count completions.
        for (int v = 0; v < NV; v++) begin
            int got;
            @(negedge clk);
            req_valid = VEC[v][31:24];
            req_cls   = VEC[v][23:8];
            for (int i = 0; i < 8; i++) req_tag[i] = 6'(v*8 + i);
            #1;
            chk("R1 R2 R8 accept mask", int'(req_accept), int'(VEC[v][7:0]));
            got = 0;
            for (int k = 0; k < 25; k++) begin
                @(negedge clk);
                idle();
                for (int u = 0; u < 9; u++) begin
                    if (cmp_valid[u]) begin
                        got++;
                        if (cmp_tag[u] / 8 != v || !VEC[v][cmp_tag[u] % 8]) begin
                            n_chk++;
                            n_fail++;
                            $display("FAIL R7 stray tag actual=%0h expected=vector %0d", cmp_tag[u], v);
                        end
                    end
                end
            end
            chk("R7 completion count", got, $countones(VEC[v][7:0]));
        end

        // R3: ALU latency of one cycle, lane 0
        @(negedge clk);
        offer1(0, 2'd0, 6'h2A);
        #1 chk("R3 alu accept", int'(req_accept), 1);
        @(negedge clk);
        idle();
        chk("R3 alu lane0 valid", int'(cmp_valid), 9'h001);
        chk("R3 alu lane0 tag", int'(cmp_tag[0]), 'h2A);
        @(negedge clk);
        chk("R7 alu single completion", int'(cmp_valid), 0);

        // R4: back-to-back multiplies, latency three, lane 6
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                chk("R4 mul lane6 valid", int'(cmp_valid), 9'h040);
                chk("R4 mul lane6 tag", int'(cmp_tag[6]), 10 + k - 3);
            end else begin
                chk("R4 mul not early", int'(cmp_valid[6]), 0);
            end
            if (k < 3) begin
                offer1(0, 2'd1, 6'(10 + k));
                #1 chk("R4 mul accepted each cycle", int'(req_accept), 1);
            end else idle();
        end

        // R5: divide blocks the shared unit for nineteen cycles
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (k == 0) begin
                offer1(0, 2'd2, 6'd33);
                #1 chk("R5 div accept", int'(req_accept), 1);
            end else if (k < 20) begin
                chk("R5 no early div result", int'(cmp_valid[6]), 0);
                idle();
                req_valid = 8'h03;
                req_cls[0] = 2'd1; req_tag[0] = 6'd60;
                req_cls[1] = 2'd2; req_tag[1] = 6'd61;
                #1 chk("R5 mul/div refused while dividing", int'(req_accept), 0);
            end else if (k == 20) begin
                chk("R5 div result lane6", int'(cmp_valid), 9'h040);
                chk("R5 div tag", int'(cmp_tag[6]), 33);
                offer1(0, 2'd1, 6'd34);
                #1 chk("R5 accept in completion cycle", int'(req_accept), 1);
            end else begin
                idle();
                if (k == 23) begin
                    chk("R5 mul after div lane6", int'(cmp_valid), 9'h040);
                    chk("R5 mul after div tag", int'(cmp_tag[6]), 34);
                end else chk("R7 no refused completions", int'(cmp_valid), 0);
            end
        end

        // R6: spare units, latency four, not pipelined
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            idle();
            if (k == 0) begin
                req_valid = 8'h03;
                req_cls[0] = 2'd3; req_tag[0] = 6'd40;
                req_cls[1] = 2'd3; req_tag[1] = 6'd41;
                #1 chk("R6 two aux accepted", int'(req_accept), 3);
            end else if (k < 4) begin
                offer1(0, 2'd3, 6'd42);
                #1 chk("R6 aux busy refuses", int'(req_accept), 0);
            end else if (k == 4) begin
                chk("R6 aux lanes 7 and 8", int'(cmp_valid), 9'h180);
                chk("R6 aux lane7 tag", int'(cmp_tag[7]), 40);
                chk("R6 aux lane8 tag", int'(cmp_tag[8]), 41);
                offer1(0, 2'd3, 6'd43);
                #1 chk("R6 aux accept in completion cycle", int'(req_accept), 1);
            end else if (k == 8) begin
                chk("R6 aux reissue lane7", int'(cmp_valid), 9'h080);
                chk("R6 aux reissue tag", int'(cmp_tag[7]), 43);
            end
        end

        // R9: reset in the middle of a divide
        @(negedge clk);
        offer1(0, 2'd2, 6'd50);
        #1 chk("R9 div before reset accepted", int'(req_accept), 1);
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 lanes empty after reset", int'(cmp_valid), 0);
        offer1(0, 2'd2, 6'd51);
        #1 chk("R9 unit free after reset", int'(req_accept), 1);
        begin
            int got;
            got = 0;
            for (int k = 1; k <= 22; k++) begin
                @(negedge clk);
                idle();
                if (cmp_valid != '0) begin
                    got++;
                    chk("R9 only new div completes", int'(cmp_tag[6]), 51);
                    chk("R9 new div timing", k, 20);
                end
            end
            chk("R9 single completion after reset", got, 1);
        end

        finish_run();
    end

endmodule